// File: doc/BRIEF.md
# Tagged Out-of-Order Request Queue

This block is one request buffer shared by every initiator that talks to a downstream scheduler. Requests enter through a valid/ready port and are written in arrival order. Each request carries a tag, which is the ID of the initiator that sent it, and a data payload. All stored entries are shown at once on flattened per-slot buses, with an occupancy vector and an eligibility vector. An external selector picks any eligible slot and removes it by index. The selection policy is not part of this block.

Entries are kept packed and ordered by age. Slot 0 always holds the oldest request. When an entry leaves from the middle, every younger entry moves down one slot, so the age order of the survivors never changes. An entry is eligible only when no older occupied slot has the same tag. This keeps requests from one initiator in order, while requests from different initiators may pass each other. When every slot is full, the queue drops its ready, whatever is arriving. The only exception is that in the same cycle a valid removal frees a slot for the incoming request.

A removal request that names an empty or ineligible slot changes nothing and raises an error flag in that cycle. An enqueue presented in the same cycle still proceeds normally.

Top module: `oq_tagq`

## Requirements
- R1: After reset, `level` is 0, `occ` and `elig` are all zero and `in_ready` is 1.
- R2: An accepted request is stored with its tag and data in slot `level` (or `level`-1 when a removal is accepted in the same cycle), so slot 0 holds the oldest entry and higher slots hold younger ones.
- R3: `elig[i]` is 1 exactly when slot i is occupied and no lower slot is occupied with an equal tag. The occupied slot 0 is therefore always eligible.
- R4: A removal with `deq_valid`=1 naming an eligible slot asserts `deq_accept` in that cycle. At the next edge that entry is gone, and each entry above it moves down one slot, keeping its tag, data and relative order.
- R5: Entries with equal tags leave in arrival order. When all stored tags are equal, only slot 0 is eligible, and a removal naming any other slot is refused.
- R6: When `level` equals the depth and no removal is accepted in the cycle, `in_ready` is 0 and the request is not stored. `level` never exceeds the depth.
- R7: When the queue is full and a removal is accepted in the same cycle, `in_ready` is 1. A presented request is stored in the top slot and `level` stays at the depth.
- R8: A removal naming an unoccupied or ineligible slot asserts `deq_err` and not `deq_accept` in that cycle, and it leaves the stored entries unchanged. A request enqueued in the same cycle is still accepted.
- R9: `level` advances by one per accepted request and drops by one per accepted removal. Both in one cycle leave it unchanged.
- R10: Occupied slots are always contiguous from slot 0. `occ` has exactly its low `level` bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream request present |
| in_ready | output | 1 | Queue can take the request this cycle |
| in_tag | input | TAG_W | Initiator ID of the request |
| in_data | input | DATA_W | Request payload |
| deq_valid | input | 1 | Selector asks to remove a slot |
| deq_idx | input | IDX_W | Slot to remove, 0 = oldest |
| deq_accept | output | 1 | Removal taken this cycle |
| deq_err | output | 1 | Removal named an empty or ineligible slot |
| level | output | CNT_W | Number of stored entries |
| occ | output | DEPTH | Per-slot occupied flags |
| elig | output | DEPTH | Per-slot eligibility flags |
| ent_tag | output | DEPTH*TAG_W | Slot tags, slot i at bits i*TAG_W |
| ent_data | output | DEPTH*DATA_W | Slot payloads, slot i at bits i*DATA_W |

## Verification
On every cycle, the assertions check that the occupancy is packed against the level counter, that the level is bounded, and that it steps correctly. They also check that a full queue refuses input unless a removal frees a slot, that eligibility is a subset of occupancy with the head always eligible, and that a refused removal neither fires nor moves the level. Only the bench scenarios can show the rest. That covers where a new entry lands, that removal from the middle shifts younger entries down with their payloads intact, that equal-tag requests come out in arrival order, and that reset clears the queue while it holds data.

// File: rtl/oq_pkg.sv
package oq_pkg;

  // Per-slot update selected each cycle by the storage array.
  typedef enum logic [1:0] {
    SLOT_HOLD  = 2'd0,
    SLOT_SHIFT = 2'd1,
    SLOT_LOAD  = 2'd2,
    SLOT_CLEAR = 2'd3
  } slot_op_e;

endpackage

// File: rtl/oq_ctrl.sv
module oq_ctrl #(
  parameter int DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic                               deq_valid,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] deq_idx,
  input  logic [DEPTH-1:0]                   elig,
  output logic                               in_ready,
  output logic                               enq_fire,
  output logic                               deq_fire,
  output logic                               deq_err,
  output logic [$clog2(DEPTH+1)-1:0]         level,
  output logic [$clog2(DEPTH+1)-1:0]         wr_pos
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] level_q;
  logic             idx_hit;

  // Index names a slot that exists and is currently eligible.
  function automatic logic idx_legal(input logic [IDX_W-1:0] idx,
                                     input logic [DEPTH-1:0] e);
    logic ok;
    ok = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(idx) == k) ok = e[k];
    end
    return ok;
  endfunction

  // Occupancy after one cycle of enqueue and dequeue.
  function automatic logic [CNT_W-1:0] step_level(input logic [CNT_W-1:0] lv,
                                                  input logic up,
                                                  input logic dn);
    return lv + CNT_W'(up) - CNT_W'(dn);
  endfunction

  // Slot a new entry lands in, after any same-cycle compaction.
  function automatic logic [CNT_W-1:0] place_at(input logic [CNT_W-1:0] lv,
                                                input logic dn);
    return dn ? (lv - CNT_W'(1)) : lv;
  endfunction

  always_comb begin
    idx_hit  = idx_legal(deq_idx, elig);
    deq_fire = deq_valid && idx_hit;
    deq_err  = deq_valid && !idx_hit;
    in_ready = (level_q != FULL_LVL) || deq_fire;
    enq_fire = in_valid && in_ready;
    wr_pos   = place_at(level_q, deq_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= step_level(level_q, enq_fire, deq_fire);
  end

  assign level = level_q;

endmodule

// File: rtl/oq_elig.sv
module oq_elig #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 3
) (
  input  logic [DEPTH-1:0]       occ,
  input  logic [DEPTH*TAG_W-1:0] tags,
  output logic [DEPTH-1:0]       elig
);

  logic [TAG_W-1:0] tag_a [DEPTH];
  logic [DEPTH-1:0] blocked;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign tag_a[g] = tags[g*TAG_W +: TAG_W];

    // A slot is held back by any older occupied slot carrying its tag.
    always_comb begin
      blocked[g] = 1'b0;
      for (int j = 0; j < g; j++) begin
        if (occ[j] && (tag_a[j] == tag_a[g])) blocked[g] = 1'b1;
      end
    end

    assign elig[g] = occ[g] && !blocked[g];
  end

endmodule

// File: rtl/oq_store.sv
module oq_store
  import oq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               enq_fire,
  input  logic [$clog2(DEPTH+1)-1:0]         wr_pos,
  input  logic [TAG_W-1:0]                   wr_tag,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               deq_fire,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] deq_idx,
  output logic [DEPTH-1:0]                   occ,
  output logic [DEPTH*TAG_W-1:0]             tags,
  output logic [DEPTH*DATA_W-1:0]            datas
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              vld_q  [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  slot_op_e          op     [DEPTH];

  // Value each slot takes on a shift; the top slot takes nothing.
  logic              up_vld  [DEPTH];
  logic [TAG_W-1:0]  up_tag  [DEPTH];
  logic [DATA_W-1:0] up_data [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [CNT_W-1:0] POS_C = CNT_W'(g);
    localparam logic [IDX_W-1:0] IDX_C = IDX_W'(g);

    if (g < DEPTH - 1) begin : g_mid
      assign up_vld[g]  = vld_q[g+1];
      assign up_tag[g]  = tag_q[g+1];
      assign up_data[g] = data_q[g+1];
    end else begin : g_top
      assign up_vld[g]  = 1'b0;
      assign up_tag[g]  = '0;
      assign up_data[g] = '0;
    end

    always_comb begin
      if (enq_fire && (wr_pos == POS_C))      op[g] = SLOT_LOAD;
      else if (deq_fire && (IDX_C >= deq_idx)) op[g] = (g == DEPTH - 1) ? SLOT_CLEAR : SLOT_SHIFT;
      else                                     op[g] = SLOT_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else begin
        case (op[g])
          SLOT_LOAD: begin
            vld_q[g]  <= 1'b1;
            tag_q[g]  <= wr_tag;
            data_q[g] <= wr_data;
          end
          SLOT_SHIFT: begin
            vld_q[g]  <= up_vld[g];
            tag_q[g]  <= up_tag[g];
            data_q[g] <= up_data[g];
          end
          SLOT_CLEAR: vld_q[g] <= 1'b0;
          default: ;
        endcase
      end
    end

    assign occ[g]                     = vld_q[g];
    assign tags[g*TAG_W +: TAG_W]     = tag_q[g];
    assign datas[g*DATA_W +: DATA_W]  = data_q[g];
  end

endmodule

// File: rtl/oq_tagq.sv
module oq_tagq #(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [TAG_W-1:0]         in_tag,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     deq_valid,
  input  logic [IDX_W-1:0]         deq_idx,
  output logic                     deq_accept,
  output logic                     deq_err,
  output logic [CNT_W-1:0]         level,
  output logic [DEPTH-1:0]         occ,
  output logic [DEPTH-1:0]         elig,
  output logic [DEPTH*TAG_W-1:0]   ent_tag,
  output logic [DEPTH*DATA_W-1:0]  ent_data
);

  // Internal events, named for the checker and for waveform reading.
  logic             enq_fire;
  logic             deq_fire;
  logic [CNT_W-1:0] wr_pos;

  oq_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_fire (enq_fire),
    .wr_pos   (wr_pos),
    .wr_tag   (in_tag),
    .wr_data  (in_data),
    .deq_fire (deq_fire),
    .deq_idx  (deq_idx),
    .occ      (occ),
    .tags     (ent_tag),
    .datas    (ent_data)
  );

  oq_elig #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_elig (
    .occ  (occ),
    .tags (ent_tag),
    .elig (elig)
  );

  oq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .deq_valid (deq_valid),
    .deq_idx   (deq_idx),
    .elig      (elig),
    .in_ready  (in_ready),
    .enq_fire  (enq_fire),
    .deq_fire  (deq_fire),
    .deq_err   (deq_err),
    .level     (level),
    .wr_pos    (wr_pos)
  );

  assign deq_accept = deq_fire;

endmodule

// File: rtl/oq_tagq_chk.sv
module oq_tagq_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             deq_accept,
  input logic             deq_err,
  input logic [CNT_W-1:0] level,
  input logic [DEPTH-1:0] occ,
  input logic [DEPTH-1:0] elig
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic             enq_ev;
  logic [DEPTH-1:0] low_mask;

  assign enq_ev = in_valid && in_ready;

  always_comb begin
    low_mask = '0;
    for (int k = 0; k < DEPTH; k++) low_mask[k] = (k < int'(level));
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);  // R6

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (level == FULL_LVL && !deq_accept) |-> !in_ready);  // R6

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (level == FULL_LVL && deq_accept && in_valid) |=> (level == FULL_LVL));  // R7

  AST_ELIG_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (elig & ~occ) == '0);  // R3

  AST_HEAD_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    occ[0] |-> elig[0]);  // R3

  AST_OCC_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    occ == low_mask);  // R10

  AST_ERR_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    deq_err |-> !deq_accept);  // R8

  AST_ERR_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_err && !enq_ev) |=> $stable(level));  // R8

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) + CNT_W'($past(enq_ev)) - CNT_W'($past(deq_accept))));  // R9

endmodule

bind oq_tagq oq_tagq_chk #(.DEPTH(DEPTH)) u_oq_tagq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .deq_accept (deq_accept),
  .deq_err    (deq_err),
  .level      (level),
  .occ        (occ),
  .elig       (elig)
);

// File: tb/test_oq_tagq.sv
`timescale 1ns/1ps
module test_oq_tagq;

  localparam int D  = 4;
  localparam int TW = 2;
  localparam int DW = 8;
  localparam int IW = 2;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [TW-1:0] in_tag = '0;
  logic [DW-1:0] in_data = '0;
  logic          deq_valid = 1'b0;
  logic [IW-1:0] deq_idx = '0;
  logic          deq_accept;
  logic          deq_err;
  logic [CW-1:0] level;
  logic [D-1:0]  occ;
  logic [D-1:0]  elig;
  logic [D*TW-1:0] ent_tag;
  logic [D*DW-1:0] ent_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  oq_tagq #(.DEPTH(D), .TAG_W(TW), .DATA_W(DW)) i_oq_tagq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_data(in_data), .deq_valid(deq_valid), .deq_idx(deq_idx),
    .deq_accept(deq_accept), .deq_err(deq_err), .level(level), .occ(occ),
    .elig(elig), .ent_tag(ent_tag), .ent_data(ent_data)
  );

  typedef struct packed {
    logic          en;
    logic [TW-1:0] tag;
    logic [DW-1:0] data;
    logic          dq;
    logic [IW-1:0] idx;
    logic          rdy;
    logic          err;
    logic [CW-1:0] lvl;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 8'd10, 1'b0, 2'd0, 1'b1, 1'b0, 3'd1},
    '{1'b1, 2'd2, 8'd20, 1'b0, 2'd0, 1'b1, 1'b0, 3'd2},
    '{1'b1, 2'd1, 8'd11, 1'b0, 2'd0, 1'b1, 1'b0, 3'd3},
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd2, 1'b1, 1'b1, 3'd3},  // ineligible slot
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd3, 1'b1, 1'b1, 3'd3},  // empty slot
    '{1'b1, 2'd3, 8'd30, 1'b0, 2'd0, 1'b1, 1'b0, 3'd4},
    '{1'b1, 2'd0, 8'd40, 1'b0, 2'd0, 1'b0, 1'b0, 3'd4},  // full, refused
    '{1'b1, 2'd0, 8'd40, 1'b1, 2'd1, 1'b1, 1'b0, 3'd4},  // R7 swap from middle
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd0, 1'b1, 1'b0, 3'd3},
    '{1'b1, 2'd3, 8'd31, 1'b1, 2'd0, 1'b1, 1'b0, 3'd3},
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd2, 1'b1, 1'b1, 3'd3},
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd1, 1'b1, 1'b0, 3'd2},
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd0, 1'b1, 1'b0, 3'd1},
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd0, 1'b1, 1'b0, 3'd0},
    '{1'b1, 2'd2, 8'd50, 1'b1, 2'd0, 1'b1, 1'b1, 3'd1},  // bad deq, enq proceeds
    '{1'b0, 2'd0, 8'd0,  1'b1, 2'd0, 1'b1, 1'b0, 3'd0}
  };

  // Bench-side picture of the queue, oldest first.
  logic [TW-1:0] m_tag  [D];
  logic [DW-1:0] m_data [D];
  int            m_cnt = 0;

  function automatic logic m_elig(input int s);
    if (s >= m_cnt) return 1'b0;
    for (int j = 0; j < s; j++) if (m_tag[j] == m_tag[s]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_slots();
    for (int s = 0; s < D; s++) begin
      check("R10 occupancy", 32'(occ[s]), 32'(s < m_cnt));
      check("R3 eligibility", 32'(elig[s]), 32'(m_elig(s)));
      if (s < m_cnt) begin
        check("R2 slot tag", 32'(ent_tag[s*TW +: TW]), 32'(m_tag[s]));
        check("R4 slot data", 32'(ent_data[s*DW +: DW]), 32'(m_data[s]));
      end
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input vec_t v);
    logic ok, rdy;
    in_valid = v.en; in_tag = v.tag; in_data = v.data;
    deq_valid = v.dq; deq_idx = v.idx;
    #1;
    ok  = v.dq && m_elig(int'(v.idx));
    rdy = (m_cnt < D) || ok;
    check("R6 in_ready", 32'(in_ready), 32'(v.rdy));
    check("R8 deq_err", 32'(deq_err), 32'(v.err));
    check("R4 deq_accept", 32'(deq_accept), 32'(ok));
    if (ok) begin
      for (int j = int'(v.idx); j < D - 1; j++) begin
        m_tag[j] = m_tag[j+1]; m_data[j] = m_data[j+1];
      end
      m_cnt--;
    end
    if (v.en && rdy) begin
      m_tag[m_cnt] = v.tag; m_data[m_cnt] = v.data; m_cnt++;
    end
    @(negedge clk);
    in_valid = 1'b0; deq_valid = 1'b0;
    check("R9 level", 32'(level), 32'(v.lvl));
    check_slots();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 level", 32'(level), 32'd0);
    check("R1 occ", 32'(occ), 32'd0);
    check("R1 elig", 32'(elig), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R5: four entries with one tag leave strictly in arrival order.
    for (int k = 0; k < D; k++) begin
      v = '{1'b1, 2'd2, 8'(k + 1), 1'b0, 2'd0, 1'b1, 1'b0, 3'(k + 1)};
      step(v);
    end
    check("R5 only head eligible", 32'(elig), 32'b0001);
    v = '{1'b0, 2'd0, 8'd0, 1'b1, 2'd2, 1'b0, 1'b1, 3'd4};
    step(v);  // R5 non-head refused, queue full so ready low
    for (int k = 0; k < D; k++) begin
      check("R5 head order", 32'(ent_data[DW-1:0]), 32'(k + 1));
      v = '{1'b0, 2'd0, 8'd0, 1'b1, 2'd0, 1'b1, 1'b0, 3'(D - 1 - k)};
      step(v);
    end

    // R1: reset while holding entries clears the queue.
    for (int k = 0; k < 2; k++) begin
      v = '{1'b1, 2'(k), 8'(k + 60), 1'b0, 2'd0, 1'b1, 1'b0, 3'(k + 1)};
      step(v);
    end
    rst_n = 1'b0;
    m_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 level after reset", 32'(level), 32'd0);
    check("R1 occ after reset", 32'(occ), 32'd0);
    check("R1 ready after reset", 32'(in_ready), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule